// File: doc/BRIEF.md
# Root Port Request Forwarder

This block is the routing core of a root port that software sees as a PCI-to-PCI bridge. It takes one configuration or memory request at a time from the upstream side. It compares the request against the port's secondary and subordinate bus numbers and its two memory windows. It then does one of the following:

- answers the request itself,
- converts a type 1 configuration request to type 0 and sends it downstream,
- forwards the request downstream unchanged,
- completes it locally with an error.

Every request produces exactly one upstream completion. That completion carries the request's tag and the port's own bus/device/function number. Failed configuration reads are given all-ones data.

The bridge registers arrive as inputs and are assumed stable while a request is in flight. Encodings used throughout:

| Item | Encoding |
|---|---|
| Request kind | 0 = type 0 configuration, 1 = type 1 configuration, 2 = memory, 3 = reserved |
| Completion status | 0 = success, 1 = unsupported request, 2 = retry status, 3 = completer abort |
| Device number | bits [7:3] of the device/function field |
| Own ID (`own_bdf`) | {bus[15:8], device[7:3], function[2:0]} |

When the retry-visibility input is low, the port re-issues a configuration request that came back with retry status. It does so up to `MAX_RETRY` times and then treats the request as failed.

Every forwarded request waits for its downstream completion. Memory writes are therefore handled as non-posted here. Configuration writes to the port itself have no effect, because the register file lies outside this block.

Top module: `rp_fwd`

## Requirements
- R1: A type 1 configuration request with bus number greater than `sec_bus` and less than or equal to `sub_bus` is sent downstream once, as kind 1, with bus, device/function, tag and write flag unchanged, provided the link is up.
- R2: A type 1 configuration request whose bus equals `sec_bus` and whose device number is 0 is sent downstream as kind 0, with the same bus and device/function, provided the link is up.
- R3: A type 1 configuration request whose bus is below `sec_bus` or above `sub_bus` is never sent downstream. It completes with status 1 and data 0, whatever the link state.
- R4: A type 0 configuration request is never sent downstream. It completes with status 0; a read returns `self_rdata` and a write returns data 0.
- R5: A memory request whose address lies inclusively inside either [`np_base`,`np_limit`] or [`pf_base`,`pf_limit`] is forwarded once, with its address. Any other memory address completes with status 1 and is not forwarded.
- R6: Every downstream request carries `own_bdf` as requester ID. Every upstream completion carries `own_bdf` as completer ID and echoes the tag of its request.
- R7: A configuration read completes with status 0 and data 32'hFFFFFFFF in three cases: it targets a nonzero device on the secondary bus, it receives status 1 from downstream, or the link is down while its bus is in range. A configuration write in any of these cases completes with status 1 and data 0.
- R8: While `link_up` is low nothing is sent downstream, and memory requests complete with status 1.
- R9: With `crs_vis_en` high, a downstream retry status (2) on a configuration request is passed upstream as status 2 with data 0, after a single issue.
- R10: With `crs_vis_en` low, a downstream retry status causes the same request to be re-issued. After `MAX_RETRY` re-issues (`MAX_RETRY`+1 issues in all), the next retry status is treated as a failure under R7's rules.
- R11: Only one request is in progress at a time. `up_req_ready` is low from acceptance until the completion. A request answered locally completes in the cycle after acceptance. A forwarded request completes in the cycle after its downstream completion arrives.
- R12: After reset, `up_req_ready` is high and `dn_req_valid` and `up_cpl_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Downstream link is up |
| crs_vis_en | input | 1 | Pass retry status upstream instead of re-issuing |
| own_bdf | input | 16 | Port's own bus/device/function number |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| np_base | input | ADDR_W | Non-prefetchable window base (inclusive) |
| np_limit | input | ADDR_W | Non-prefetchable window limit (inclusive) |
| pf_base | input | ADDR_W | Prefetchable window base (inclusive) |
| pf_limit | input | ADDR_W | Prefetchable window limit (inclusive) |
| self_rdata | input | DATA_W | Data returned for type 0 reads of the port |
| up_req_valid | input | 1 | Upstream request present |
| up_req_ready | output | 1 | Port can accept a request |
| up_req_kind | input | 2 | Request kind |
| up_req_write | input | 1 | 1 = write |
| up_req_tag | input | TAG_W | Request tag |
| up_req_bus | input | 8 | Target bus number |
| up_req_devfn | input | 8 | Target device/function |
| up_req_addr | input | ADDR_W | Memory address |
| up_req_data | input | DATA_W | Write data |
| up_cpl_valid | output | 1 | Upstream completion, one cycle |
| up_cpl_status | output | 2 | Completion status |
| up_cpl_tag | output | TAG_W | Echoed tag |
| up_cpl_data | output | DATA_W | Read data |
| up_cpl_cid | output | 16 | Completer ID |
| dn_req_valid | output | 1 | Downstream request, one cycle |
| dn_req_kind | output | 2 | Downstream request kind |
| dn_req_write | output | 1 | 1 = write |
| dn_req_tag | output | TAG_W | Tag |
| dn_req_bus | output | 8 | Bus number |
| dn_req_devfn | output | 8 | Device/function |
| dn_req_addr | output | ADDR_W | Memory address |
| dn_req_data | output | DATA_W | Write data |
| dn_req_rid | output | 16 | Requester ID |
| dn_cpl_valid | input | 1 | Downstream completion, one cycle |
| dn_cpl_status | input | 2 | Downstream completion status |
| dn_cpl_data | input | DATA_W | Downstream completion data |

## Verification
A corrupted routing decision shows up on the very request that triggers it, in one of three ways:

- a downstream issue that should not have happened, or one that is missing;
- a wrong kind field on the issued request;
- a wrong status or data word in the completion.

Each of these is visible one cycle after acceptance for local answers, or four cycles after acceptance for forwarded ones.

A broken retry counter shows as a wrong number of downstream issues for a single request. A stuck state register leaves `up_req_ready` low, and no later request is ever accepted. The sweeps cover every bus number around the secondary/subordinate range and memory addresses on both edges of both windows. They run with the link both up and down, so a decode error near a boundary appears within a few requests.

// File: rtl/rp_fwd_pkg.sv
package rp_fwd_pkg;
  typedef enum logic [1:0] {
    KIND_CFG0 = 2'd0,
    KIND_CFG1 = 2'd1,
    KIND_MEM  = 2'd2,
    KIND_RSVD = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_SC  = 2'd0,
    ST_UR  = 2'd1,
    ST_CRS = 2'd2,
    ST_CA  = 2'd3
  } cpl_stat_e;

  typedef enum logic [2:0] {
    RT_SELF,
    RT_FWD,
    RT_CONV,
    RT_FAIL,
    RT_UR
  } route_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_RESP
  } fwd_state_e;
endpackage

// File: rtl/rp_route_dec.sv
module rp_route_dec
  import rp_fwd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2
) (
  input  logic [1:0]                kind,
  input  logic [7:0]                bus,
  input  logic [7:0]                devfn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      link_up,
  input  logic [7:0]                sec_bus,
  input  logic [7:0]                sub_bus,
  input  logic [NUM_WIN*ADDR_W-1:0] win_base,
  input  logic [NUM_WIN*ADDR_W-1:0] win_limit,
  output route_e                    route
);
  logic [NUM_WIN-1:0] win_hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_hit[w] = (addr >= win_base[w*ADDR_W +: ADDR_W]) &&
                        (addr <= win_limit[w*ADDR_W +: ADDR_W]);
  end

  logic at_sec, below_sub_range;
  assign at_sec          = (bus == sec_bus);
  assign below_sub_range = (bus > sec_bus) && (bus <= sub_bus);

  always_comb begin
    route = RT_UR;
    unique case (kind)
      KIND_CFG0: route = RT_SELF;
      KIND_CFG1: begin
        if (at_sec) begin
          // only device 0 exists beyond a point-to-point link
          route = ((devfn[7:3] != 5'd0) || !link_up) ? RT_FAIL : RT_CONV;
        end else if (below_sub_range) begin
          route = link_up ? RT_FWD : RT_FAIL;
        end else begin
          route = RT_UR;
        end
      end
      KIND_MEM:  route = ((|win_hit) && link_up) ? RT_FWD : RT_UR;
      default:   route = RT_UR;
    endcase
  end
endmodule

// File: rtl/rp_cpl_form.sv
module rp_cpl_form
  import rp_fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              is_cfg,
  input  logic              is_write,
  input  logic [1:0]        dn_stat,
  input  logic [DATA_W-1:0] dn_data,
  input  logic              crs_vis_en,
  input  logic              retry_ok,
  output logic              retry,
  output logic [1:0]        out_stat,
  output logic [DATA_W-1:0] out_data
);
  logic failed;

  always_comb begin
    retry    = 1'b0;
    failed   = 1'b0;
    out_stat = dn_stat;
    out_data = is_write ? '0 : dn_data;
    if (is_cfg) begin
      unique case (dn_stat)
        ST_UR:  failed = 1'b1;
        ST_CRS: begin
          if (crs_vis_en) begin
            out_stat = ST_CRS;
            out_data = '0;
          end else if (retry_ok) begin
            retry = 1'b1;
          end else begin
            failed = 1'b1;
          end
        end
        ST_CA:  out_data = '0;
        default: ;
      endcase
      if (failed) begin
        out_stat = is_write ? ST_UR : ST_SC;
        out_data = is_write ? '0 : '1;
      end
    end
  end
endmodule

// File: rtl/rp_fwd.sv
module rp_fwd
  import rp_fwd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 8,
  parameter int MAX_RETRY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              crs_vis_en,
  input  logic [15:0]       own_bdf,
  input  logic [7:0]        sec_bus,
  input  logic [7:0]        sub_bus,
  input  logic [ADDR_W-1:0] np_base,
  input  logic [ADDR_W-1:0] np_limit,
  input  logic [ADDR_W-1:0] pf_base,
  input  logic [ADDR_W-1:0] pf_limit,
  input  logic [DATA_W-1:0] self_rdata,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [1:0]        up_req_kind,
  input  logic              up_req_write,
  input  logic [TAG_W-1:0]  up_req_tag,
  input  logic [7:0]        up_req_bus,
  input  logic [7:0]        up_req_devfn,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic [DATA_W-1:0] up_req_data,
  output logic              up_cpl_valid,
  output logic [1:0]        up_cpl_status,
  output logic [TAG_W-1:0]  up_cpl_tag,
  output logic [DATA_W-1:0] up_cpl_data,
  output logic [15:0]       up_cpl_cid,
  output logic              dn_req_valid,
  output logic [1:0]        dn_req_kind,
  output logic              dn_req_write,
  output logic [TAG_W-1:0]  dn_req_tag,
  output logic [7:0]        dn_req_bus,
  output logic [7:0]        dn_req_devfn,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic [DATA_W-1:0] dn_req_data,
  output logic [15:0]       dn_req_rid,
  input  logic              dn_cpl_valid,
  input  logic [1:0]        dn_cpl_status,
  input  logic [DATA_W-1:0] dn_cpl_data
);
  localparam int NUM_WIN = 2;
  localparam int RTY_W   = $clog2(MAX_RETRY + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  fwd_state_e         state_q, state_d;
  logic [RTY_W-1:0]   rty_q, rty_d;
  logic               ld_req, ld_cpl;
  logic [1:0]         cpl_stat_d, cpl_stat_q;
  logic [DATA_W-1:0]  cpl_data_d, cpl_data_q;
  logic [1:0]         h_kind, h_kind_d;
  logic               h_write;
  logic [TAG_W-1:0]   h_tag;
  logic [7:0]         h_bus, h_devfn;
  logic [ADDR_W-1:0]  h_addr;
  logic [DATA_W-1:0]  h_data;

  route_e route;
  rp_route_dec #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_dec (
    .kind      (up_req_kind),
    .bus       (up_req_bus),
    .devfn     (up_req_devfn),
    .addr      (up_req_addr),
    .link_up   (link_up),
    .sec_bus   (sec_bus),
    .sub_bus   (sub_bus),
    .win_base  ({pf_base, np_base}),
    .win_limit ({pf_limit, np_limit}),
    .route     (route)
  );

  logic              fm_retry;
  logic [1:0]        fm_stat;
  logic [DATA_W-1:0] fm_data;
  logic              retry_ok;
  assign retry_ok = (rty_q < RTY_W'(MAX_RETRY));

  rp_cpl_form #(.DATA_W(DATA_W)) u_form (
    .is_cfg     (h_kind != KIND_MEM),
    .is_write   (h_write),
    .dn_stat    (dn_cpl_status),
    .dn_data    (dn_cpl_data),
    .crs_vis_en (crs_vis_en),
    .retry_ok   (retry_ok),
    .retry      (fm_retry),
    .out_stat   (fm_stat),
    .out_data   (fm_data)
  );

  // next state
  always_comb begin
    state_d    = state_q;
    rty_d      = rty_q;
    ld_req     = 1'b0;
    ld_cpl     = 1'b0;
    cpl_stat_d = ST_SC;
    cpl_data_d = '0;
    h_kind_d   = (route == RT_CONV) ? KIND_CFG0 : up_req_kind;
    unique case (state_q)
      S_IDLE: if (up_req_valid) begin
        ld_req = 1'b1;
        rty_d  = '0;
        unique case (route)
          RT_FWD, RT_CONV: state_d = S_ISSUE;
          RT_SELF: begin
            state_d = S_RESP; ld_cpl = 1'b1;
            cpl_data_d = up_req_write ? '0 : self_rdata;
          end
          RT_FAIL: begin
            state_d = S_RESP; ld_cpl = 1'b1;
            cpl_stat_d = up_req_write ? ST_UR : ST_SC;
            cpl_data_d = up_req_write ? '0 : '1;
          end
          default: begin
            state_d = S_RESP; ld_cpl = 1'b1;
            cpl_stat_d = ST_UR;
          end
        endcase
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: if (dn_cpl_valid) begin
        if (fm_retry) begin
          rty_d   = rty_q + 1'b1;
          state_d = S_ISSUE;
        end else begin
          state_d = S_RESP; ld_cpl = 1'b1;
          cpl_stat_d = fm_stat;
          cpl_data_d = fm_data;
        end
      end
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= S_IDLE;
      rty_q   <= '0;
    end else begin
      state_q <= state_d;
      rty_q   <= rty_d;
    end
  end

  // data registers with explicit enables, no reset
  always_ff @(posedge clk) begin
    if (ld_req) begin
      h_kind  <= h_kind_d;
      h_write <= up_req_write;
      h_tag   <= up_req_tag;
      h_bus   <= up_req_bus;
      h_devfn <= up_req_devfn;
      h_addr  <= up_req_addr;
      h_data  <= up_req_data;
    end
    if (ld_cpl) begin
      cpl_stat_q <= cpl_stat_d;
      cpl_data_q <= cpl_data_d;
    end
  end

  assign up_req_ready  = (state_q == S_IDLE);
  assign up_cpl_valid  = (state_q == S_RESP);
  assign up_cpl_status = cpl_stat_q;
  assign up_cpl_data   = cpl_data_q;
  assign up_cpl_tag    = h_tag;
  assign up_cpl_cid    = own_bdf;
  assign dn_req_valid  = (state_q == S_ISSUE);
  assign dn_req_kind   = h_kind;
  assign dn_req_write  = h_write;
  assign dn_req_tag    = h_tag;
  assign dn_req_bus    = h_bus;
  assign dn_req_devfn  = h_devfn;
  assign dn_req_addr   = h_addr;
  assign dn_req_data   = h_data;
  assign dn_req_rid    = own_bdf;

  // R1
  fwd_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (dn_req_valid && dn_req_kind == KIND_CFG1) |->
      (dn_req_bus > sec_bus) && (dn_req_bus <= sub_bus));

  // R2
  conv_target_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (dn_req_valid && dn_req_kind == KIND_CFG0) |->
      (dn_req_bus == sec_bus) && (dn_req_devfn[7:3] == 5'd0));

  // R5
  mem_window_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (dn_req_valid && dn_req_kind == KIND_MEM) |->
      ((dn_req_addr >= np_base) && (dn_req_addr <= np_limit)) ||
      ((dn_req_addr >= pf_base) && (dn_req_addr <= pf_limit)));

  // R7
  ur_ones_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == S_WAIT && dn_cpl_valid && dn_cpl_status == ST_UR &&
     h_kind != KIND_MEM && !h_write) |=>
      (up_cpl_valid && up_cpl_data == '1 && up_cpl_status == ST_SC));

  // R11
  single_issue_chk: assert property (@(posedge clk) disable iff (!arst_n)
    dn_req_valid |=> !dn_req_valid);

  // R11
  cpl_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    up_cpl_valid |=> (up_req_ready && !up_cpl_valid));
endmodule

// File: tb/rp_fwd_test.sv
module rp_fwd_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int MR = 3;
  localparam logic [7:0] SEC = 8'd4;
  localparam logic [7:0] SUB = 8'd7;
  localparam logic [15:0] BDF = 16'h0310;
  localparam logic [31:0] SELF = 32'h1234ABCD;
  localparam logic [31:0] ONES = 32'hFFFFFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic link_up = 1'b1, crs_vis_en = 1'b1;
  logic up_req_valid = 1'b0, up_req_ready;
  logic [1:0] up_req_kind = '0;
  logic up_req_write = 1'b0;
  logic [TW-1:0] up_req_tag = '0;
  logic [7:0] up_req_bus = '0, up_req_devfn = '0;
  logic [AW-1:0] up_req_addr = '0;
  logic [DW-1:0] up_req_data = '0;
  logic up_cpl_valid;
  logic [1:0] up_cpl_status;
  logic [TW-1:0] up_cpl_tag;
  logic [DW-1:0] up_cpl_data;
  logic [15:0] up_cpl_cid;
  logic dn_req_valid, dn_req_write;
  logic [1:0] dn_req_kind;
  logic [TW-1:0] dn_req_tag;
  logic [7:0] dn_req_bus, dn_req_devfn;
  logic [AW-1:0] dn_req_addr;
  logic [DW-1:0] dn_req_data;
  logic [15:0] dn_req_rid;
  logic dn_cpl_valid = 1'b0;
  logic [1:0] dn_cpl_status = '0;
  logic [DW-1:0] dn_cpl_data = '0;

  rp_fwd #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .MAX_RETRY(MR)) uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .crs_vis_en(crs_vis_en),
    .own_bdf(BDF), .sec_bus(SEC), .sub_bus(SUB),
    .np_base(16'h1000), .np_limit(16'h1FFF), .pf_base(16'h8000), .pf_limit(16'h9FFF),
    .self_rdata(SELF),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready), .up_req_kind(up_req_kind),
    .up_req_write(up_req_write), .up_req_tag(up_req_tag), .up_req_bus(up_req_bus),
    .up_req_devfn(up_req_devfn), .up_req_addr(up_req_addr), .up_req_data(up_req_data),
    .up_cpl_valid(up_cpl_valid), .up_cpl_status(up_cpl_status), .up_cpl_tag(up_cpl_tag),
    .up_cpl_data(up_cpl_data), .up_cpl_cid(up_cpl_cid),
    .dn_req_valid(dn_req_valid), .dn_req_kind(dn_req_kind), .dn_req_write(dn_req_write),
    .dn_req_tag(dn_req_tag), .dn_req_bus(dn_req_bus), .dn_req_devfn(dn_req_devfn),
    .dn_req_addr(dn_req_addr), .dn_req_data(dn_req_data), .dn_req_rid(dn_req_rid),
    .dn_cpl_valid(dn_cpl_valid), .dn_cpl_status(dn_cpl_status), .dn_cpl_data(dn_cpl_data)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // downstream completer model
  int resp_cnt = 0, issues = 0, crs_left = 0;
  logic [1:0] final_stat = 2'd0;
  logic [DW-1:0] ds_data = '0;
  logic [1:0] cap_kind; logic cap_write; logic [TW-1:0] cap_tag;
  logic [7:0] cap_bus, cap_devfn; logic [AW-1:0] cap_addr; logic [15:0] cap_rid;

  always @(negedge clk) begin
    dn_cpl_valid <= 1'b0;
    if (resp_cnt != 0) begin
      resp_cnt <= resp_cnt - 1;
      if (resp_cnt == 1) begin
        dn_cpl_valid  <= 1'b1;
        dn_cpl_status <= (crs_left != 0) ? 2'd2 : final_stat;
        dn_cpl_data   <= ds_data;
        if (crs_left != 0) crs_left <= crs_left - 1;
      end
    end
    if (dn_req_valid) begin
      issues <= issues + 1;
      resp_cnt <= 2;
      cap_kind <= dn_req_kind; cap_write <= dn_req_write; cap_tag <= dn_req_tag;
      cap_bus <= dn_req_bus; cap_devfn <= dn_req_devfn; cap_addr <= dn_req_addr;
      cap_rid <= dn_req_rid;
    end
  end

  logic [TW-1:0] tag_ctr = '0;
  logic [1:0] got_stat; logic [DW-1:0] got_data;
  int got_lat, got_iss;
  bit ready_leak;

  task automatic do_req(input logic [1:0] k, input logic w, input logic [7:0] b,
                        input logic [7:0] df, input logic [AW-1:0] a);
    int base_iss;
    @(negedge clk);
    tag_ctr = tag_ctr + 1'b1;
    ds_data = {8'hD0, b, a};
    up_req_valid = 1'b1; up_req_kind = k; up_req_write = w; up_req_bus = b;
    up_req_devfn = df; up_req_addr = a; up_req_data = ~{16'h0, a}; up_req_tag = tag_ctr;
    base_iss = issues;
    ready_leak = 1'b0;
    @(posedge clk);
    @(negedge clk);
    up_req_valid = 1'b0;
    got_lat = 1;
    while (!up_cpl_valid && got_lat < 100) begin
      if (up_req_ready) ready_leak = 1'b1;
      @(negedge clk);
      got_lat++;
    end
    chk(up_cpl_valid, "R11", "completion arrives", 32'(up_cpl_valid), 32'd1);
    got_stat = up_cpl_status;
    got_data = up_cpl_data;
    got_iss  = issues - base_iss;
    // R6: tag echo and completer ID
    chk(up_cpl_tag == tag_ctr, "R6", "tag", 32'(up_cpl_tag), 32'(tag_ctr));
    chk(up_cpl_cid == BDF, "R6", "completer id", 32'(up_cpl_cid), 32'(BDF));
    chk(!ready_leak, "R11", "ready low while busy", 32'(ready_leak), 32'd0);
  endtask

  task automatic expect_res(input string req, input logic [1:0] es, input logic [31:0] ed,
                            input int eiss, input bit chk_lat);
    chk(got_stat == es, req, "status", 32'(got_stat), 32'(es));
    chk(got_data == ed, req, "data", got_data, ed);
    chk(got_iss == eiss, req, "downstream issues", 32'(got_iss), 32'(eiss));
    if (chk_lat)
      chk(got_lat == ((eiss == 0) ? 1 : 4), "R11", "latency", 32'(got_lat),
          32'((eiss == 0) ? 1 : 4));
    if (eiss != 0)
      chk(cap_rid == BDF && cap_tag == tag_ctr, "R6", "requester id/tag",
          {cap_rid, 12'h0, cap_tag}, {BDF, 12'h0, tag_ctr});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(up_req_ready && !dn_req_valid && !up_cpl_valid, "R12", "reset outputs",
        {29'd0, up_req_ready, dn_req_valid, up_cpl_valid}, 32'b100);

    // bus-number sweep, type 1, link up
    for (int b = 0; b < 12; b++) begin
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < 2; w++) begin
          do_req(2'd1, w[0], 8'(b), {5'(d), 3'd2}, '0);
          if (b < int'(SEC) || b > int'(SUB)) begin
            expect_res("R3", 2'd1, 32'd0, 0, 1);
          end else if (b == int'(SEC) && d != 0) begin
            expect_res("R7", w ? 2'd1 : 2'd0, w ? 32'd0 : ONES, 0, 1);
          end else if (b == int'(SEC)) begin
            expect_res("R2", 2'd0, w ? 32'd0 : {8'hD0, 8'(b), 16'h0}, 1, 1);
            chk(cap_kind == 2'd0 && cap_bus == 8'(b) && cap_devfn == {5'd0, 3'd2},
                "R2", "converted kind/bus/devfn", {8'h0, 6'h0, cap_kind, cap_bus, cap_devfn},
                {8'h0, 6'h0, 2'd0, 8'(b), 5'd0, 3'd2});
          end else begin
            expect_res("R1", 2'd0, w ? 32'd0 : {8'hD0, 8'(b), 16'h0}, 1, 1);
            chk(cap_kind == 2'd1 && cap_bus == 8'(b) && cap_devfn == {5'(d), 3'd2} &&
                cap_write == w[0], "R1", "forwarded kind/bus/devfn/write",
                {7'h0, cap_write, 6'h0, cap_kind, cap_bus, cap_devfn},
                {7'h0, w[0], 6'h0, 2'd1, 8'(b), 5'(d), 3'd2});
          end
        end
      end
    end

    // type 0 to the port itself
    for (int i = 0; i < 4; i++) begin
      do_req(2'd0, i[0], 8'(i * 3), 8'(i * 9), '0);
      expect_res("R4", 2'd0, i[0] ? 32'd0 : SELF, 0, 1);
    end

    // downstream unsupported request on a config access
    final_stat = 2'd1;
    do_req(2'd1, 1'b0, 8'd6, 8'h08, '0);
    expect_res("R7", 2'd0, ONES, 1, 1);
    do_req(2'd1, 1'b1, 8'd4, 8'h00, '0);
    expect_res("R7", 2'd1, 32'd0, 1, 1);
    do_req(2'd2, 1'b0, 8'd0, 8'd0, 16'h1800);
    expect_res("R5", 2'd1, {8'hD0, 8'd0, 16'h1800}, 1, 1);
    final_stat = 2'd0;

    // memory sweep, all 256 pages, both page edges
    for (int i = 0; i < 256; i++) begin
      logic [AW-1:0] a;
      bit hit;
      a = {8'(i), i[0] ? 8'hFF : 8'h00};
      hit = (a >= 16'h1000 && a <= 16'h1FFF) || (a >= 16'h8000 && a <= 16'h9FFF);
      do_req(2'd2, i[1], 8'd0, 8'd0, a);
      if (hit) begin
        expect_res("R5", 2'd0, i[1] ? 32'd0 : {8'hD0, 8'd0, a}, 1, 1);
        chk(cap_addr == a && cap_kind == 2'd2, "R5", "forwarded address",
            {14'h0, cap_kind, cap_addr}, {14'h0, 2'd2, a});
      end else begin
        expect_res("R5", 2'd1, 32'd0, 0, 1);
      end
    end

    // link down
    link_up = 1'b0;
    for (int b = 2; b < 10; b++) begin
      for (int w = 0; w < 2; w++) begin
        do_req(2'd1, w[0], 8'(b), 8'h00, '0);
        if (b < int'(SEC) || b > int'(SUB)) expect_res("R3", 2'd1, 32'd0, 0, 1);
        else expect_res("R7", w ? 2'd1 : 2'd0, w ? 32'd0 : ONES, 0, 1);
      end
    end
    do_req(2'd2, 1'b0, 8'd0, 8'd0, 16'h1234);
    expect_res("R8", 2'd1, 32'd0, 0, 1);
    do_req(2'd2, 1'b1, 8'd0, 8'd0, 16'h9000);
    expect_res("R8", 2'd1, 32'd0, 0, 1);
    do_req(2'd0, 1'b0, 8'd0, 8'd0, '0);
    expect_res("R4", 2'd0, SELF, 0, 1);
    link_up = 1'b1;

    // retry status visible
    crs_vis_en = 1'b1;
    crs_left = 1;
    do_req(2'd1, 1'b0, 8'd5, 8'h00, '0);
    expect_res("R9", 2'd2, 32'd0, 1, 1);
    crs_left = 0;

    // retry status hidden: recovers within the limit
    crs_vis_en = 1'b0;
    crs_left = 2;
    do_req(2'd1, 1'b0, 8'd5, 8'h00, '0);
    expect_res("R10", 2'd0, {8'hD0, 8'd5, 16'h0}, 3, 0);
    crs_left = 1;
    do_req(2'd1, 1'b0, 8'd4, 8'h00, '0);
    expect_res("R10", 2'd0, {8'hD0, 8'd4, 16'h0}, 2, 0);
    // exhausted
    crs_left = 20;
    do_req(2'd1, 1'b0, 8'd7, 8'h00, '0);
    expect_res("R10", 2'd0, ONES, MR + 1, 0);
    crs_left = 20;
    do_req(2'd1, 1'b1, 8'd6, 8'h00, '0);
    expect_res("R10", 2'd1, 32'd0, MR + 1, 0);
    crs_left = 0;
    crs_vis_en = 1'b1;

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule